// File: doc/BRIEF.md
# Condition-Gated Data-Processing ALU

This block is the integer execute stage of a load/store processor. Each cycle it takes one data-processing instruction: a 4-bit operation code, a 4-bit condition code, a set-flags bit, the destination register index, operand A, and operand B. Operand B has already passed through the barrel shifter, and the shifter's carry-out comes with it. The block first tests the condition code against the current N, Z, C and V flags. If the test passes, it produces the result, a write-enable for the destination register, and the next flag values. It raises a mode-restore pulse when the instruction writes the program counter with set-flags on.

All outputs are registered, so they appear one clock after the inputs. The block has no internal state apart from the output registers. The current flags are an input and the next flags are an output, so the status register stays with its owner. The operand and register-index widths are parameters. The program-counter index is the highest register index.

Top module: `cg_dp_alu`

## Requirements
- R1: Operation codes produce these results: 0 A&B, 1 A^B, 8 A&B, 9 A^B, 12 A|B, 13 B, 14 A&~B, 15 ~B. Arithmetic codes produce: 2 A−B, 3 B−A, 4 A+B, 5 A+B+C, 6 A−B−1+C, 7 B−A−1+C, 10 A−B, 11 A+B. C is the current carry flag. The result appears on the result output whether or not the condition passes.
- R2: Codes 8 to 11 never assert write-enable. All other codes assert it when the condition passes.
- R3: The condition codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always, 15 never. The flag vector is packed as bit 3 N, bit 2 Z, bit 1 C, bit 0 V.
- R4: Logical codes (0, 1, 8, 9, 12 to 15) with set-flags set N to result bit 31 and Z to result==0. They set C to the shifter carry input and keep V.
- R5: Arithmetic codes with set-flags set N and Z from the result. For additions, C is the carry out of bit 31. For subtractions, C is set when there is no borrow. V is set on signed overflow of the 32-bit operation.
- R6: When set-flags is clear, the flag output equals the flag input.
- R7: A writing code with set-flags on, destination index 15 and a passing condition raises the restore output. The flag output then equals the flag input. Codes 8 to 11 with destination 15 update the flags normally and do not raise restore.
- R8: When the condition fails, write-enable and restore are low and the flag output equals the flag input.
- R9: Outputs are registered: they reflect the inputs present at the previous rising clock edge. While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_i | input | 4 | Operation code |
| cond_i | input | 4 | Condition code |
| set_flags_i | input | 1 | Update flags when set |
| rd_i | input | RADDR_W | Destination register index |
| a_i | input | DATA_W | Operand A |
| b_i | input | DATA_W | Shifted operand B |
| shift_c_i | input | 1 | Shifter carry-out |
| flags_i | input | 4 | Current N,Z,C,V |
| result_o | output | DATA_W | Operation result |
| wr_en_o | output | 1 | Destination write-enable |
| flags_o | output | 4 | Next N,Z,C,V |
| restore_o | output | 1 | Mode-restore pulse |

## Verification
Several of the block's functions can fall in the same cycle. The most delicate pair is the condition gate and the program-counter restore: a failed condition must cancel a restore that would otherwise fire. Compare codes with destination 15 also meet the restore rule, and they must update the flags anyway. The bench sweeps every operation code against every condition code and every flag vector, with destination 15 selected in a regular pattern. For each vector it judges write-enable, restore and flags against a model built from the requirements.

// File: rtl/cg_dp_alu_pkg.sv
package cg_dp_alu_pkg;
   typedef enum logic [3:0] {
      OP_AND   = 4'h0, OP_XOR   = 4'h1, OP_SUB   = 4'h2, OP_RSUB  = 4'h3,
      OP_ADD   = 4'h4, OP_ADDC  = 4'h5, OP_SUBC  = 4'h6, OP_RSUBC = 4'h7,
      OP_TAND  = 4'h8, OP_TXOR  = 4'h9, OP_CSUB  = 4'hA, OP_CADD  = 4'hB,
      OP_OR    = 4'hC, OP_PASS  = 4'hD, OP_CLR   = 4'hE, OP_NOT   = 4'hF
   } alu_op_e;

   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_C = 1;
   localparam int FLG_V = 0;

   function automatic logic op_is_arith(input logic [3:0] op);
      unique case (op)
         OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC, OP_RSUBC, OP_CSUB, OP_CADD: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic op_writes(input logic [3:0] op);
      return op[3:2] != 2'b10;
   endfunction
endpackage

// File: rtl/cg_cond_eval.sv
module cg_cond_eval
   import cg_dp_alu_pkg::*;
(
   input  logic [3:0] cond_i,
   input  logic [3:0] flags_i,
   output logic       pass_o
);
   logic n, z, c, v;
   assign n = flags_i[FLG_N];
   assign z = flags_i[FLG_Z];
   assign c = flags_i[FLG_C];
   assign v = flags_i[FLG_V];

   always_comb begin
      unique case (cond_i)
         4'h0: pass_o = z;
         4'h1: pass_o = !z;
         4'h2: pass_o = c;
         4'h3: pass_o = !c;
         4'h4: pass_o = n;
         4'h5: pass_o = !n;
         4'h6: pass_o = v;
         4'h7: pass_o = !v;
         4'h8: pass_o = c && !z;
         4'h9: pass_o = !c || z;
         4'hA: pass_o = (n == v);
         4'hB: pass_o = (n != v);
         4'hC: pass_o = !z && (n == v);
         4'hD: pass_o = z || (n != v);
         4'hE: pass_o = 1'b1;
         default: pass_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/cg_arith_unit.sv
module cg_arith_unit
   import cg_dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              c_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              c_o,
   output logic              v_o
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] x, y;
   logic              cin;
   logic [DATA_W:0]   full;

   // One adder serves every arithmetic code: operands are swapped/inverted ahead of it.
   always_comb begin
      x   = a_i;
      y   = b_i;
      cin = 1'b0;
      unique case (op_i)
         OP_SUB, OP_CSUB: begin y = ~b_i; cin = 1'b1; end
         OP_RSUB:         begin x = b_i; y = ~a_i; cin = 1'b1; end
         OP_ADDC:         begin cin = c_i; end
         OP_SUBC:         begin y = ~b_i; cin = c_i; end
         OP_RSUBC:        begin x = b_i; y = ~a_i; cin = c_i; end
         default:         begin cin = 1'b0; end
      endcase
   end

   assign full  = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
   assign sum_o = full[MSB:0];
   assign c_o   = full[DATA_W];
   assign v_o   = (x[MSB] == y[MSB]) && (sum_o[MSB] != x[MSB]);
endmodule

// File: rtl/cg_logic_unit.sv
module cg_logic_unit
   import cg_dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o
);
   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
      always_comb begin
         unique case (op_i)
            OP_AND, OP_TAND: res_o[gi] = a_i[gi] & b_i[gi];
            OP_XOR, OP_TXOR: res_o[gi] = a_i[gi] ^ b_i[gi];
            OP_OR:           res_o[gi] = a_i[gi] | b_i[gi];
            OP_PASS:         res_o[gi] = b_i[gi];
            OP_CLR:          res_o[gi] = a_i[gi] & ~b_i[gi];
            OP_NOT:          res_o[gi] = ~b_i[gi];
            default:         res_o[gi] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/cg_dp_alu.sv
module cg_dp_alu
   import cg_dp_alu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int RADDR_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         op_i,
   input  logic [3:0]         cond_i,
   input  logic               set_flags_i,
   input  logic [RADDR_W-1:0] rd_i,
   input  logic [DATA_W-1:0]  a_i,
   input  logic [DATA_W-1:0]  b_i,
   input  logic               shift_c_i,
   input  logic [3:0]         flags_i,
   output logic [DATA_W-1:0]  result_o,
   output logic               wr_en_o,
   output logic [3:0]         flags_o,
   output logic               restore_o
);
   localparam int MSB = DATA_W - 1;
   localparam logic [RADDR_W-1:0] PC_IDX = {RADDR_W{1'b1}};

   if (DATA_W < 2) begin : g_bad_width
      $error("cg_dp_alu: DATA_W must be at least 2");
   end
   if (RADDR_W < 1) begin : g_bad_raddr
      $error("cg_dp_alu: RADDR_W must be at least 1");
   end

   logic              pass;
   logic [DATA_W-1:0] sum, lres, res;
   logic              ar_c, ar_v;
   logic              is_arith, writes, restore_req, wr_d;
   logic [3:0]        flags_d;

   cg_cond_eval u_cond (
      .cond_i (cond_i),
      .flags_i(flags_i),
      .pass_o (pass)
   );

   cg_arith_unit #(.DATA_W(DATA_W)) u_arith (
      .op_i (op_i),
      .a_i  (a_i),
      .b_i  (b_i),
      .c_i  (flags_i[FLG_C]),
      .sum_o(sum),
      .c_o  (ar_c),
      .v_o  (ar_v)
   );

   cg_logic_unit #(.DATA_W(DATA_W)) u_logic (
      .op_i (op_i),
      .a_i  (a_i),
      .b_i  (b_i),
      .res_o(lres)
   );

   assign is_arith    = op_is_arith(op_i);
   assign writes      = op_writes(op_i);
   assign res         = is_arith ? sum : lres;
   assign restore_req = pass && set_flags_i && writes && (rd_i == PC_IDX);
   assign wr_d        = pass && writes;

   always_comb begin
      flags_d = flags_i;
      if (pass && set_flags_i && !restore_req) begin
         flags_d[FLG_N] = res[MSB];
         flags_d[FLG_Z] = (res == '0);
         flags_d[FLG_C] = is_arith ? ar_c : shift_c_i;
         flags_d[FLG_V] = is_arith ? ar_v : flags_i[FLG_V];
      end
   end

   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o  <= '0;
         wr_en_o   <= 1'b0;
         flags_o   <= '0;
         restore_o <= 1'b0;
         past_ok   <= 1'b0;
      end else begin
         result_o  <= res;
         wr_en_o   <= wr_d;
         flags_o   <= flags_d;
         restore_o <= restore_req;
         past_ok   <= 1'b1;
      end
   end

   AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(op_i[3:2] == 2'b10) |-> !wr_en_o); // R2
   AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(!pass) |-> !wr_en_o && !restore_o && flags_o == $past(flags_i)); // R8
   AST_NOSET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(!set_flags_i) |-> flags_o == $past(flags_i) && !restore_o); // R6
   AST_RESTORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && restore_o |-> flags_o == $past(flags_i) && wr_en_o); // R7
   AST_LOGIC_CV: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(pass && set_flags_i && !is_arith && !restore_req)
      |-> flags_o[FLG_V] == $past(flags_i[FLG_V]) && flags_o[FLG_C] == $past(shift_c_i)); // R4
   AST_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(pass && set_flags_i && !restore_req)
      |-> flags_o[FLG_Z] == (result_o == '0) && flags_o[FLG_N] == result_o[MSB]); // R5
endmodule

// File: tb/cg_dp_alu_test.sv
module cg_dp_alu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_i = '0, cond_i = '0, flags_i = '0, rd_i = '0;
   logic        set_flags_i = 1'b0, shift_c_i = 1'b0;
   logic [31:0] a_i = '0, b_i = '0;
   logic [31:0] result_o;
   logic        wr_en_o, restore_o;
   logic [3:0]  flags_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   cg_dp_alu #(.DATA_W(32), .RADDR_W(4)) uut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .cond_i(cond_i),
      .set_flags_i(set_flags_i), .rd_i(rd_i), .a_i(a_i), .b_i(b_i),
      .shift_c_i(shift_c_i), .flags_i(flags_i), .result_o(result_o),
      .wr_en_o(wr_en_o), .flags_o(flags_o), .restore_o(restore_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic cond_ok(input logic [3:0] cc, input logic [3:0] f);
      logic n, z, c, v;
      {n, z, c, v} = f;
      case (cc)
         0: return z;          1: return !z;
         2: return c;          3: return !c;
         4: return n;          5: return !n;
         6: return v;          7: return !v;
         8: return c & !z;     9: return !c | z;
         10: return n == v;    11: return n != v;
         12: return !z & (n == v);
         13: return z | (n != v);
         14: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic apply(input logic [3:0] op, input logic [3:0] cc, input logic [3:0] f,
                        input logic sf, input logic [3:0] rd, input logic [31:0] a,
                        input logic [31:0] b, input logic sc);
      logic [31:0] er;
      logic        ec, ev, arith, sub, pass, ew, erest;
      logic [3:0]  ef;
      logic [63:0] wide;
      longint      sres;
      logic        cf;
      @(negedge clk);
      op_i = op; cond_i = cc; flags_i = f; set_flags_i = sf; rd_i = rd;
      a_i = a; b_i = b; shift_c_i = sc;
      cf = f[1];
      arith = 1'b1; sub = 1'b0; ec = 1'b0; ev = 1'b0;
      case (op)
         2, 10: begin er = a - b; sub = 1'b1;
                   ec = a >= b; sres = longint'($signed(a)) - longint'($signed(b)); end
         3:     begin er = b - a; sub = 1'b1;
                   ec = b >= a; sres = longint'($signed(b)) - longint'($signed(a)); end
         4, 11: begin wide = {32'd0, a} + {32'd0, b}; er = wide[31:0]; ec = wide[32];
                   sres = longint'($signed(a)) + longint'($signed(b)); end
         5:     begin wide = {32'd0, a} + {32'd0, b} + {63'd0, cf}; er = wide[31:0]; ec = wide[32];
                   sres = longint'($signed(a)) + longint'($signed(b)) + longint'(cf); end
         6:     begin er = a - b - 32'd1 + {31'd0, cf};
                   ec = ({32'd0, a} + {63'd0, cf}) > {32'd0, b};
                   sres = longint'($signed(a)) - longint'($signed(b)) - 1 + longint'(cf); end
         7:     begin er = b - a - 32'd1 + {31'd0, cf};
                   ec = ({32'd0, b} + {63'd0, cf}) > {32'd0, a};
                   sres = longint'($signed(b)) - longint'($signed(a)) - 1 + longint'(cf); end
         default: begin
            arith = 1'b0; sres = 0;
            case (op)
               0, 8:  er = a & b;
               1, 9:  er = a ^ b;
               12:    er = a | b;
               13:    er = b;
               14:    er = a & ~b;
               default: er = ~b;
            endcase
         end
      endcase
      if (arith) ev = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
      pass  = cond_ok(cc, f);
      ew    = pass && !(op >= 8 && op <= 11);
      erest = ew && sf && (rd == 4'd15);
      ef    = f;
      if (pass && sf && !erest) begin
         ef[3] = er[31];
         ef[2] = (er == 32'd0);
         ef[1] = arith ? ec : sc;
         ef[0] = arith ? ev : f[0];
      end
      @(posedge clk);
      #1;
      chk(arith ? "R1/R5 result" : "R1 result", result_o, er);
      chk((op >= 8 && op <= 11) ? "R2 no-write" : "R3/R2 write-enable", {31'd0, wr_en_o}, {31'd0, ew});
      chk(!pass ? "R8 failed-cond flags" : (!sf ? "R6 flags held" :
          (erest ? "R7 restore flags" : (arith ? "R5 arith flags" : "R4 logic flags"))),
          {28'd0, flags_o}, {28'd0, ef});
      chk("R7 restore", {31'd0, restore_o}, {31'd0, erest});
      if (sub && sf && pass) begin end
   endtask

   initial begin
      #150000;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] pa [6];
      logic [31:0] pb [6];
      pa[0] = 32'h0;        pb[0] = 32'h0;
      pa[1] = 32'hFFFFFFFF; pb[1] = 32'h1;
      pa[2] = 32'h7FFFFFFF; pb[2] = 32'h1;
      pa[3] = 32'h80000000; pb[3] = 32'h80000000;
      pa[4] = 32'h12345678; pb[4] = 32'h0F0F0F0F;
      pa[5] = 32'h5;        pb[5] = 32'h9;
      op_i = 4'hD; b_i = 32'hDEADBEEF; flags_i = 4'hF; cond_i = 4'hE; set_flags_i = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R9 reset result", result_o, 32'd0);
      chk("R9 reset wr_en", {31'd0, wr_en_o}, 32'd0);
      chk("R9 reset flags", {28'd0, flags_o}, 32'd0);
      chk("R9 reset restore", {31'd0, restore_o}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int p = 0; p < 6; p++) begin
         for (int op = 0; op < 16; op++) begin
            for (int cc = 0; cc < 16; cc++) begin
               for (int f = 0; f < 16; f++) begin
                  logic sf, sc;
                  logic [3:0] rd;
                  sf = (p[0] ^ f[0] ^ cc[1]) | (p == 4);
                  sc = p[1] ^ op[0] ^ f[2];
                  rd = ((op + cc + f) % 3 == 0) ? 4'd15 : 4'd2;
                  apply(4'(op), 4'(cc), 4'(f), sf, rd, pa[p], pb[p], sc);
               end
            end
         end
      end
      // R9: output follows the inputs of the previous edge only
      apply(4'hD, 4'hE, 4'h0, 1'b0, 4'd1, 32'h0, 32'hA5A5A5A5, 1'b0);
      @(negedge clk);
      b_i = 32'h0;
      #1;
      chk("R9 registered output", result_o, 32'hA5A5A5A5);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule